// File: doc/BRIEF.md
# Upper-Bank Function Group Router

This block connects three on-chip peripherals to fixed groups of pads in the upper part of an I/O bank. The bank has 99 digital pads, numbered 0 to 98, and any of them can work as plain GPIO. This block handles the 27 pads from 72 to 98. Pad N appears on bit N-72 of every pad-side vector.

The three peripherals are:
- a serial NOR flash port, which can sit on either of two pad sets;
- a primary UART with TX and RX;
- a 10-signal eMMC bus.

For each pad the block produces an output value, an output enable and an ownership flag. Each peripheral input is taken from the pad that owns it. Any pad that no enabled function claims falls back to the GPIO output and output-enable registers.

Software programs three registers through an address/data/write-strobe port. The routing is combinational from those registers, so a new setting appears on the clock edge that captures the write.

The eMMC pads overlap the second flash pad set. A fixed rule gives eMMC priority on those pads, and a status output reports the clash.

Top module: `pin_group_sel`

## Requirements
- R1: After reset, all of the following hold: every bit of `pad_fn_o`, `pad_oe_o` and `pad_out_o` is 0, `conflict_o` is 0, and `fl_din_o`, `uart_rx_o` and every bit of `emmc_in_o` read 1.
- R2: A write is a high `cfg_we_i` at a rising edge, and it takes effect at that edge. The registers are:
  - Address 0 sets the function control: bits 1:0 are the flash select, bit 2 is the UART enable and bit 3 is the eMMC enable.
  - Address 1 sets the GPIO output values.
  - Address 2 sets the GPIO output enables.
  - Address 3 is ignored.
  - Until the edge, the outputs keep the previous routing.
- R3: With flash select 1, pads 83, 84, 86 and 87 carry clock, chip select, data-out and data-in, in that order. The first three are driven with output enable 1. Pad 87 is input-only, and `fl_din_o` follows its input.
- R4: With flash select 2 and eMMC disabled, pads 76, 78, 79 and 81 carry clock, chip select, data-out and data-in, in that order. Drive and input rules are the same as in R3.
- R5: With flash select 0 or 3, no pad is owned by the flash port and `fl_din_o` reads 1.
- R6: With the UART enabled, pad 88 drives `uart_tx_i` with output enable 1. Pad 89 is input-only and feeds `uart_rx_o`. With the UART disabled, `uart_rx_o` reads 1 and neither pad is owned.
- R7: With eMMC enabled, pad 72+i carries eMMC signal i for i = 0..9. Its value and output enable come from `emmc_out_i[i]` and `emmc_oe_i[i]`, and `emmc_in_o[i]` follows the pad input. With eMMC disabled, `emmc_in_o` reads all ones.
- R8: With eMMC enabled and flash select 2, the conflict case applies:
  - eMMC owns pads 72 to 81.
  - The flash port is unrouted, so `fl_din_o` reads 1.
  - `conflict_o` is 1.
  - In every other setting `conflict_o` is 0.
- R9: `pad_fn_o[k]` is 1 exactly on pads owned by an enabled function. Every pad that is not owned drives the GPIO output register bit k with the GPIO enable register bit k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register address |
| cfg_wdata_i | input | 27 | Register write data |
| fl_sck_i | input | 1 | Flash clock from the flash controller |
| fl_csn_i | input | 1 | Flash chip select from the flash controller |
| fl_dout_i | input | 1 | Flash serial data toward the device |
| fl_din_o | output | 1 | Flash serial data from the device (1 when unrouted) |
| uart_tx_i | input | 1 | UART transmit data |
| uart_rx_o | output | 1 | UART receive data (1 when disabled) |
| emmc_out_i | input | 10 | eMMC signal output values |
| emmc_oe_i | input | 10 | eMMC signal output enables |
| emmc_in_o | output | 10 | eMMC signal inputs (all 1 when disabled) |
| pad_in_i | input | 27 | Pad input levels, bit k is pad 72+k |
| pad_out_o | output | 27 | Pad output values |
| pad_oe_o | output | 27 | Pad output enables |
| pad_fn_o | output | 27 | Pad owned by a function |
| conflict_o | output | 1 | eMMC and the second flash set are both requested |

## Verification
Two things can coincide in one cycle:
- eMMC and the second flash option can both claim pads 76, 78, 79 and 81.
- A register write can change the routing while peripheral data is still flowing.

The bench sweeps all sixteen function-control values, so every overlap combination is reached. Each setting is checked with several patterns of pad and peripheral data. Every output is compared with a pad-by-pad model built from the pad numbers in the requirements. On writes, the outputs are also sampled in the half cycle before the capturing edge, which shows that the old routing holds until the edge.

// File: rtl/pin_group_sel_pkg.sv
package pin_group_sel_pkg;

  typedef enum logic [1:0] {
    OWN_GPIO  = 2'd0,
    OWN_EMMC  = 2'd1,
    OWN_FLASH = 2'd2,
    OWN_UART  = 2'd3
  } owner_e;

  typedef struct packed {
    owner_e     owner;
    logic [3:0] sig;
  } pad_route_t;

  typedef struct packed {
    logic       emmc_en;
    logic       uart_en;
    logic [1:0] fl_sel;
  } func_cfg_t;

  localparam int FL_SIGS   = 4;
  localparam int FL_DIN    = 3;
  localparam int EMMC_SIGS = 10;

  // pad indices relative to the first pad of the bank slice (pad 72)
  localparam int FL_SITE_A [FL_SIGS] = '{11, 12, 14, 15};
  localparam int FL_SITE_B [FL_SIGS] = '{4, 6, 7, 9};
  localparam int EMMC_BASE   = 0;
  localparam int UART_TX_PAD = 16;
  localparam int UART_RX_PAD = 17;
  localparam int MIN_PADS    = 18;

  localparam logic [1:0] FL_SEL_A = 2'd1;
  localparam logic [1:0] FL_SEL_B = 2'd2;

  localparam logic [1:0] ADDR_FUNC = 2'd0;
  localparam logic [1:0] ADDR_GOUT = 2'd1;
  localparam logic [1:0] ADDR_GOE  = 2'd2;

endpackage

// File: rtl/pgs_cfg_regs.sv
module pgs_cfg_regs
  import pin_group_sel_pkg::*;
#(
  parameter int NUM_PADS = 27,
  parameter int ADDR_W   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [NUM_PADS-1:0] wdata_i,
  output func_cfg_t           func_q,
  output logic [NUM_PADS-1:0] gout_q,
  output logic [NUM_PADS-1:0] goe_q
);

  localparam int FUNC_W = $bits(func_cfg_t);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      func_q <= '0;
      gout_q <= '0;
      goe_q  <= '0;
    end else if (we_i) begin
      case (addr_i)
        ADDR_FUNC: func_q <= func_cfg_t'(wdata_i[FUNC_W-1:0]);
        ADDR_GOUT: gout_q <= wdata_i;
        ADDR_GOE:  goe_q  <= wdata_i;
        default:   ;
      endcase
    end
  end

endmodule

// File: rtl/pgs_owner_map.sv
module pgs_owner_map
  import pin_group_sel_pkg::*;
#(
  parameter int NUM_PADS = 27
) (
  input  func_cfg_t                    func_i,
  output pad_route_t [NUM_PADS-1:0]    route_o,
  output logic                         conflict_o
);

  logic site_a_on;
  logic site_b_on;

  assign site_a_on  = (func_i.fl_sel == FL_SEL_A);
  assign site_b_on  = (func_i.fl_sel == FL_SEL_B) && !func_i.emmc_en;
  assign conflict_o = (func_i.fl_sel == FL_SEL_B) && func_i.emmc_en;

  // Ownership is laid down lowest priority first; eMMC is applied last.
  always_comb begin
    for (int p = 0; p < NUM_PADS; p++) begin
      route_o[p].owner = OWN_GPIO;
      route_o[p].sig   = '0;
    end
    for (int s = 0; s < FL_SIGS; s++) begin
      if (site_a_on) begin
        route_o[FL_SITE_A[s]].owner = OWN_FLASH;
        route_o[FL_SITE_A[s]].sig   = 4'(s);
      end
      if (site_b_on) begin
        route_o[FL_SITE_B[s]].owner = OWN_FLASH;
        route_o[FL_SITE_B[s]].sig   = 4'(s);
      end
    end
    if (func_i.uart_en) begin
      route_o[UART_TX_PAD].owner = OWN_UART;
      route_o[UART_TX_PAD].sig   = 4'd0;
      route_o[UART_RX_PAD].owner = OWN_UART;
      route_o[UART_RX_PAD].sig   = 4'd1;
    end
    if (func_i.emmc_en) begin
      for (int s = 0; s < EMMC_SIGS; s++) begin
        route_o[EMMC_BASE + s].owner = OWN_EMMC;
        route_o[EMMC_BASE + s].sig   = 4'(s);
      end
    end
  end

endmodule

// File: rtl/pgs_pad_mux.sv
module pgs_pad_mux
  import pin_group_sel_pkg::*;
#(
  parameter int NUM_PADS = 27
) (
  input  pad_route_t [NUM_PADS-1:0] route_i,
  input  logic [NUM_PADS-1:0]       gout_i,
  input  logic [NUM_PADS-1:0]       goe_i,
  input  logic [2:0]                fl_tx_i,
  input  logic                      uart_tx_i,
  input  logic [EMMC_SIGS-1:0]      emmc_out_i,
  input  logic [EMMC_SIGS-1:0]      emmc_oe_i,
  output logic [NUM_PADS-1:0]       pad_out_o,
  output logic [NUM_PADS-1:0]       pad_oe_o,
  output logic [NUM_PADS-1:0]       pad_fn_o
);

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    always_comb begin
      pad_out_o[p] = 1'b0;
      pad_oe_o[p]  = 1'b0;
      pad_fn_o[p]  = 1'b1;
      unique case (route_i[p].owner)
        OWN_EMMC: begin
          if (int'(route_i[p].sig) < EMMC_SIGS) begin
            pad_out_o[p] = emmc_out_i[route_i[p].sig];
            pad_oe_o[p]  = emmc_oe_i[route_i[p].sig];
          end
        end
        OWN_FLASH: begin
          if (int'(route_i[p].sig) < FL_DIN) begin
            pad_out_o[p] = fl_tx_i[route_i[p].sig[1:0]];
            pad_oe_o[p]  = 1'b1;
          end
        end
        OWN_UART: begin
          if (route_i[p].sig == 4'd0) begin
            pad_out_o[p] = uart_tx_i;
            pad_oe_o[p]  = 1'b1;
          end
        end
        default: begin
          pad_out_o[p] = gout_i[p];
          pad_oe_o[p]  = goe_i[p];
          pad_fn_o[p]  = 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/pgs_in_route.sv
module pgs_in_route
  import pin_group_sel_pkg::*;
#(
  parameter int NUM_PADS = 27
) (
  input  pad_route_t [NUM_PADS-1:0] route_i,
  input  logic [NUM_PADS-1:0]       pad_in_i,
  output logic                      fl_din_o,
  output logic                      uart_rx_o,
  output logic [EMMC_SIGS-1:0]      emmc_in_o
);

  // Unowned peripheral inputs rest at the idle-high level.
  always_comb begin
    fl_din_o  = 1'b1;
    uart_rx_o = 1'b1;
    emmc_in_o = '1;
    for (int p = 0; p < NUM_PADS; p++) begin
      case (route_i[p].owner)
        OWN_FLASH:
          if (int'(route_i[p].sig) == FL_DIN) fl_din_o = pad_in_i[p];
        OWN_UART:
          if (route_i[p].sig == 4'd1) uart_rx_o = pad_in_i[p];
        OWN_EMMC:
          if (int'(route_i[p].sig) < EMMC_SIGS) emmc_in_o[route_i[p].sig] = pad_in_i[p];
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/pin_group_sel.sv
module pin_group_sel
  import pin_group_sel_pkg::*;
#(
  parameter int NUM_PADS = 27,
  parameter int ADDR_W   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we_i,
  input  logic [ADDR_W-1:0]    cfg_addr_i,
  input  logic [NUM_PADS-1:0]  cfg_wdata_i,
  input  logic                 fl_sck_i,
  input  logic                 fl_csn_i,
  input  logic                 fl_dout_i,
  output logic                 fl_din_o,
  input  logic                 uart_tx_i,
  output logic                 uart_rx_o,
  input  logic [9:0]           emmc_out_i,
  input  logic [9:0]           emmc_oe_i,
  output logic [9:0]           emmc_in_o,
  input  logic [NUM_PADS-1:0]  pad_in_i,
  output logic [NUM_PADS-1:0]  pad_out_o,
  output logic [NUM_PADS-1:0]  pad_oe_o,
  output logic [NUM_PADS-1:0]  pad_fn_o,
  output logic                 conflict_o
);

  func_cfg_t                 func_q;
  logic [NUM_PADS-1:0]       gout_q;
  logic [NUM_PADS-1:0]       goe_q;
  pad_route_t [NUM_PADS-1:0] route;
  logic [2:0]                fl_tx;

  assign fl_tx = {fl_dout_i, fl_csn_i, fl_sck_i};

  pgs_cfg_regs #(.NUM_PADS(NUM_PADS), .ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .func_q  (func_q),
    .gout_q  (gout_q),
    .goe_q   (goe_q)
  );

  pgs_owner_map #(.NUM_PADS(NUM_PADS)) u_map (
    .func_i     (func_q),
    .route_o    (route),
    .conflict_o (conflict_o)
  );

  pgs_pad_mux #(.NUM_PADS(NUM_PADS)) u_mux (
    .route_i    (route),
    .gout_i     (gout_q),
    .goe_i      (goe_q),
    .fl_tx_i    (fl_tx),
    .uart_tx_i  (uart_tx_i),
    .emmc_out_i (emmc_out_i),
    .emmc_oe_i  (emmc_oe_i),
    .pad_out_o  (pad_out_o),
    .pad_oe_o   (pad_oe_o),
    .pad_fn_o   (pad_fn_o)
  );

  pgs_in_route #(.NUM_PADS(NUM_PADS)) u_in (
    .route_i   (route),
    .pad_in_i  (pad_in_i),
    .fl_din_o  (fl_din_o),
    .uart_rx_o (uart_rx_o),
    .emmc_in_o (emmc_in_o)
  );

endmodule

// File: rtl/pin_group_sel_chk.sv
module pin_group_sel_chk #(
  parameter int NUM_PADS = 27,
  parameter int ADDR_W   = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cfg_we_i,
  input logic [ADDR_W-1:0]   cfg_addr_i,
  input logic [NUM_PADS-1:0] cfg_wdata_i,
  input logic                fl_din_o,
  input logic                uart_tx_i,
  input logic [NUM_PADS-1:0] pad_out_o,
  input logic [NUM_PADS-1:0] pad_oe_o,
  input logic [NUM_PADS-1:0] pad_fn_o,
  input logic                conflict_o
);

  // R2 and R9: a GPIO value write shows on every unowned pad after the edge
  p_gpio_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we_i && cfg_addr_i == 2'd1) |=>
      (((pad_out_o ^ $past(cfg_wdata_i)) & ~pad_fn_o) == '0));

  // R6: the UART RX pad never drives while owned
  p_rx_input_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pad_fn_o[17] |-> !pad_oe_o[17]);

  // R6: the UART TX pad drives the transmit data
  p_tx_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pad_fn_o[16] |-> (pad_oe_o[16] && pad_out_o[16] == uart_tx_i));

  // R8: on a conflict eMMC holds pads 72..81 and flash is unrouted
  p_conflict_emmc_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    conflict_o |-> ((&pad_fn_o[9:0]) && !pad_fn_o[11] && fl_din_o));

  // R9: pads above the UART pair are never taken by a function
  p_upper_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pad_fn_o[NUM_PADS-1:18] == '0);

  // R3, R4 and R5: a low flash input requires a flash data-in pad to be owned
  p_din_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_din_o |-> (pad_fn_o[15] || pad_fn_o[9]));

endmodule

bind pin_group_sel pin_group_sel_chk #(.NUM_PADS(NUM_PADS), .ADDR_W(ADDR_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_we_i    (cfg_we_i),
  .cfg_addr_i  (cfg_addr_i),
  .cfg_wdata_i (cfg_wdata_i),
  .fl_din_o    (fl_din_o),
  .uart_tx_i   (uart_tx_i),
  .pad_out_o   (pad_out_o),
  .pad_oe_o    (pad_oe_o),
  .pad_fn_o    (pad_fn_o),
  .conflict_o  (conflict_o)
);

// File: tb/pin_group_sel_tb_top.sv
module pin_group_sel_tb_top;

  localparam int NP = 27;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_addr = '0;
  logic [NP-1:0] cfg_wdata = '0;
  logic          fl_sck = 1'b0, fl_csn = 1'b0, fl_dout = 1'b0;
  logic          fl_din;
  logic          uart_tx = 1'b0;
  logic          uart_rx;
  logic [9:0]    emmc_out = '0, emmc_oe = '0;
  logic [9:0]    emmc_in;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe, pad_fn;
  logic          conflict;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [3:0]    sh_cfg  = '0;
  logic [NP-1:0] sh_gout = '0;
  logic [NP-1:0] sh_goe  = '0;

  always #10 clk = ~clk;

  pin_group_sel dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .fl_sck_i(fl_sck), .fl_csn_i(fl_csn),
    .fl_dout_i(fl_dout), .fl_din_o(fl_din), .uart_tx_i(uart_tx),
    .uart_rx_o(uart_rx), .emmc_out_i(emmc_out), .emmc_oe_i(emmc_oe),
    .emmc_in_o(emmc_in), .pad_in_i(pad_in), .pad_out_o(pad_out),
    .pad_oe_o(pad_oe), .pad_fn_o(pad_fn), .conflict_o(conflict)
  );

  task automatic chk(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h (cfg=%h)", req, act, exp, sh_cfg);
    end
  endtask

  // Model of the requirements, pad numbers written as GPIO numbers minus 72
  task automatic check_all(input string tag);
    logic [NP-1:0] e_out, e_oe, e_fn;
    logic [9:0]    e_emmc_in;
    logic          e_din, e_rx, e_conf, emmc_on, uart_on;
    logic [1:0]    sel;
    int            fp [4];
    logic [2:0]    ftx;
    bit            fl_on;
    e_out = sh_gout; e_oe = sh_goe; e_fn = '0;
    e_din = 1'b1; e_rx = 1'b1; e_emmc_in = '1;
    sel = sh_cfg[1:0]; uart_on = sh_cfg[2]; emmc_on = sh_cfg[3];
    ftx = {fl_dout, fl_csn, fl_sck};
    fl_on = 1'b0;
    if (sel == 2'd1) begin
      fp = '{83 - 72, 84 - 72, 86 - 72, 87 - 72}; fl_on = 1'b1;
    end else if (sel == 2'd2 && !emmc_on) begin
      fp = '{76 - 72, 78 - 72, 79 - 72, 81 - 72}; fl_on = 1'b1;
    end else begin
      fp = '{0, 0, 0, 0};
    end
    if (fl_on) begin
      for (int k = 0; k < 4; k++) begin
        e_fn[fp[k]] = 1'b1;
        e_out[fp[k]] = (k < 3) ? ftx[k] : 1'b0;
        e_oe[fp[k]]  = (k < 3);
      end
      e_din = pad_in[fp[3]];
    end
    if (uart_on) begin
      e_fn[88 - 72] = 1'b1; e_out[88 - 72] = uart_tx; e_oe[88 - 72] = 1'b1;
      e_fn[89 - 72] = 1'b1; e_out[89 - 72] = 1'b0;    e_oe[89 - 72] = 1'b0;
      e_rx = pad_in[89 - 72];
    end
    if (emmc_on) begin
      for (int i = 0; i < 10; i++) begin
        e_fn[i] = 1'b1; e_out[i] = emmc_out[i]; e_oe[i] = emmc_oe[i];
        e_emmc_in[i] = pad_in[i];
      end
    end
    e_conf = emmc_on && (sel == 2'd2);
    chk({tag, " R9 R3 R4 R6 R7 pad_out"}, pad_out, e_out);
    chk({tag, " R9 R3 R4 R6 R7 pad_oe"},  pad_oe,  e_oe);
    chk({tag, " R9 R5 pad_fn"},           pad_fn,  e_fn);
    chk({tag, " R8 conflict"},            NP'(conflict), NP'(e_conf));
    chk({tag, " R3 R4 R5 R8 fl_din"},     NP'(fl_din),   NP'(e_din));
    chk({tag, " R6 uart_rx"},             NP'(uart_rx),  NP'(e_rx));
    chk({tag, " R7 emmc_in"},             NP'(emmc_in),  NP'(e_emmc_in));
  endtask

  // R2: write with a check of the old routing before the capturing edge
  task automatic wr(input logic [1:0] a, input logic [NP-1:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
    #2 check_all("R2 pre-edge");
    @(negedge clk);
    cfg_we = 1'b0;
    case (a)
      2'd0: sh_cfg  = d[3:0];
      2'd1: sh_gout = d;
      2'd2: sh_goe  = d;
      default: ;
    endcase
    #1 check_all("R2 post-edge");
  endtask

  task automatic new_pattern();
    {fl_sck, fl_csn, fl_dout, uart_tx} = 4'($urandom);
    emmc_out = 10'($urandom);
    emmc_oe  = 10'($urandom);
    pad_in   = NP'($urandom);
  endtask

  initial begin
    pad_in = NP'(27'h5A5A5A5);
    emmc_out = 10'h3FF;
    #35;
    // R1: reset values
    chk("R1 pad_fn",  pad_fn, '0);
    chk("R1 pad_oe",  pad_oe, '0);
    chk("R1 pad_out", pad_out, '0);
    chk("R1 idle inputs", NP'({conflict, fl_din, uart_rx, emmc_in}), NP'({1'b0, 1'b1, 1'b1, 10'h3FF}));
    rst_n = 1'b1;
    for (int c = 0; c < 16; c++) begin
      wr(2'd1, NP'($urandom));
      wr(2'd2, NP'($urandom));
      wr(2'd0, NP'(c));
      for (int p = 0; p < 3; p++) begin
        @(negedge clk);
        new_pattern();
        #1 check_all("sweep");
      end
      // R2: address 3 must leave every register unchanged
      wr(2'd3, '1);
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule